// File: doc/BRIEF.md
# Locked Flash Program/Erase Sequencer

This block sits in front of an on-chip flash array, modelled here as a register array of 16-bit words. It turns software requests into timed program and erase operations. After reset it is locked and in read mode. Software first clears the lock with a control write that carries the access key, then picks an operation with the mode bits. A later write to an array address starts the operation. For an erase, the data of that write is a don't-care. For a program, the write supplies the data.

While an operation runs, `busy` stays high. Its length is a fixed number of timing ticks. The ticks come from a programmable prescaler that divides one of three strobe sources. Erasing sets every bit of the target range to 1. Programming can only clear bits. The array is split into small information segments and larger main segments. Any rejected access raises a sticky `acc_viol` flag and leaves the array as it was.

Top module: `flash_seq`

## Requirements
- R1: After reset, `locked` is 1, `busy` is 0, `acc_viol` is 0 and the mode is read (all mode bits 0).
- R2: Every control write must carry 0xA5 in `cfg_wdata[15:8]`. A write with any other key changes no register and sets `acc_viol`.
- R3: An array write sets `acc_viol` and changes no word in these cases: the controller is locked, the mode is read, or the address is at or beyond the array depth. Lock register (`cfg_sel`=2): bit 0 is the lock.
- R4: Word program (mode bit 2) and block program (mode bit 3) store old AND new at the written address. The mode register is at `cfg_sel`=0.
- R5: Segment erase (mode bit 0) sets to 0xFFFF every word of the one segment that holds the written address, and no other word. Information segments (words 0..127) are 64 words each. Main segments (from word 128) are 256 words each.
- R6: Mass erase (mode bit 1) sets every main word to 0xFFFF and leaves the information words unchanged. When several mode bits are set, mass erase wins over segment erase, and segment erase wins over program.
- R7: `busy` rises on the edge that accepts the starting write. It stays high for 35, 4819 or 5297 timing ticks for program, segment erase or mass erase. The timing register is at `cfg_sel`=1. Bits [7:6] pick the strobe source (0, 1 or 2; a value of 3 picks source 2). Bits [5:0] give N, and one tick is produced per N+1 strobes.
- R8: A read issued while `busy` is high returns 0x3FFF on the next cycle and does not stall. An idle read returns the stored word on the next cycle.
- R9: An array write while `busy` is high sets `acc_viol` and does not alter the array or the running operation.
- R10: Both erase mode bits clear when an erase completes. Program mode bits stay set across operations.
- R11: A keyed write to the lock register with bit 1 set clears `acc_viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 timing, 2 lock |
| cfg_wdata | input | 16 | Control write data, key in [15:8] |
| arr_we | input | 1 | Array write (starts an operation) |
| arr_re | input | 1 | Array read request |
| arr_addr | input | AW | Array word address |
| arr_wdata | input | DW | Array write data |
| arr_rdata | output | DW | Read data, valid the cycle after `arr_re` |
| src_tick | input | 3 | Three selectable timing strobe sources |
| busy | output | 1 | Timed operation in progress |
| acc_viol | output | 1 | Sticky access-violation flag |
| locked | output | 1 | Lock state |

## Verification
Programming is tried with data that clears bits the array already cleared and with data that tries to set bits again. The readback tells AND semantics apart from a plain overwrite. Segment erase is aimed at words on both sides of the 64-word and 256-word segment boundaries, which separates correct segment sizing from an off-by-one base or a wrong region. A mass erase is started with both erase bits set, which checks both its priority and that it leaves the information region alone. Busy lengths are measured under divide-by-one, divide-by-three and a source held low, so that a wrong prescaler, a wrong source choice and a wrong tick limit each show up differently.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0]  ACCESS_KEY = 8'hA5;
  localparam logic [1:0]  SEL_MODE   = 2'd0;
  localparam logic [1:0]  SEL_TIMING = 2'd1;
  localparam logic [1:0]  SEL_LOCK   = 2'd2;
  localparam logic [15:0] BUSY_FILL  = 16'h3FFF;

  typedef enum logic [1:0] {
    OP_READ,
    OP_PROG,
    OP_SEG_ERASE,
    OP_MASS_ERASE
  } op_t;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  input  logic        arr_bad,
  input  logic        erase_done,
  output op_t         mode,
  output logic [1:0]  src_sel,
  output logic [5:0]  div_n,
  output logic        locked,
  output logic        viol
);
  logic [3:0] mode_bits;
  logic       key_ok;

  assign key_ok = (cfg_wdata[15:8] == ACCESS_KEY);

  always_comb begin
    if (mode_bits[1])                    mode = OP_MASS_ERASE;
    else if (mode_bits[0])               mode = OP_SEG_ERASE;
    else if (mode_bits[2] | mode_bits[3]) mode = OP_PROG;
    else                                 mode = OP_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_bits <= '0;
      src_sel   <= '0;
      div_n     <= '0;
      locked    <= 1'b1;
      viol      <= 1'b0;
    end else begin
      if (cfg_we && !key_ok) begin
        viol <= 1'b1;
      end else if (cfg_we) begin
        case (cfg_sel)
          SEL_MODE:   mode_bits <= cfg_wdata[3:0];
          SEL_TIMING: begin
            src_sel <= cfg_wdata[7:6];
            div_n   <= cfg_wdata[5:0];
          end
          SEL_LOCK: begin
            locked <= cfg_wdata[0];
            if (cfg_wdata[1]) viol <= 1'b0;
          end
          default: ;
        endcase
      end
      if (arr_bad) viol <= 1'b1;
      if (erase_done) mode_bits[1:0] <= 2'b00;
    end
  end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int TW = 13,
  parameter int DIVW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [TW-1:0]   limit,
  input  logic [2:0]      src_tick,
  input  logic [1:0]      src_sel,
  input  logic [DIVW-1:0] div_n,
  output logic            busy,
  output logic            done
);
  logic [DIVW-1:0] pre;
  logic [TW-1:0]   cnt;
  logic [TW-1:0]   lim_q;
  logic            strobe;
  logic            tick;

  always_comb begin
    case (src_sel)
      2'd0:    strobe = src_tick[0];
      2'd1:    strobe = src_tick[1];
      default: strobe = src_tick[2];
    endcase
  end

  assign tick = busy && strobe && (pre == div_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pre   <= '0;
      cnt   <= '0;
      lim_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        pre   <= '0;
        cnt   <= '0;
        lim_q <= limit;
      end else if (busy && strobe) begin
        if (tick) begin
          pre <= '0;
          if (cnt == lim_q - TW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end else begin
          pre <= pre + DIVW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array #(
  parameter int DEPTH = 1152,
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int INFO_SEGS        = 2,
  parameter int INFO_SEG_WORDS   = 64,
  parameter int MAIN_SEGS        = 4,
  parameter int MAIN_SEG_WORDS   = 256,
  parameter int DW               = 16,
  parameter int PROG_TICKS       = 35,
  parameter int SEG_ERASE_TICKS  = 4819,
  parameter int MASS_ERASE_TICKS = 5297,
  localparam int INFO_WORDS = INFO_SEGS * INFO_SEG_WORDS,
  localparam int MAIN_WORDS = MAIN_SEGS * MAIN_SEG_WORDS,
  localparam int DEPTH      = INFO_WORDS + MAIN_WORDS,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  input  logic          arr_we,
  input  logic          arr_re,
  input  logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_wdata,
  output logic [DW-1:0] arr_rdata,
  input  logic [2:0]    src_tick,
  output logic          busy,
  output logic          acc_viol,
  output logic          locked
);
  localparam int ISEG_AW = $clog2(INFO_SEG_WORDS);
  localparam int MSEG_AW = $clog2(MAIN_SEG_WORDS);
  localparam int MAXT01  = (PROG_TICKS > SEG_ERASE_TICKS) ? PROG_TICKS : SEG_ERASE_TICKS;
  localparam int MAXT    = (MAXT01 > MASS_ERASE_TICKS) ? MAXT01 : MASS_ERASE_TICKS;
  localparam int TW      = $clog2(MAXT + 1);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  op_t           mode;
  op_t           op_q;
  logic [1:0]    src_sel;
  logic [5:0]    div_n;
  logic          in_range;
  logic          start;
  logic          arr_bad;
  logic          done;
  logic          erase_done;
  logic [TW-1:0] limit;

  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          prog_step;
  logic [AW-1:0] erase_ptr;
  logic [AW:0]   erase_rem;

  logic [AW-1:0] off_main;
  logic [AW-1:0] seg_base;
  logic [AW:0]   seg_len;

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_q;
  logic          blank_q;

  // Start and rejection of array writes
  assign in_range = ({1'b0, arr_addr} < DEPTH_W);
  assign start    = arr_we && !busy && !locked && (mode != OP_READ) && in_range;
  assign arr_bad  = arr_we && !start;

  // Segment that holds the written address
  assign off_main = arr_addr - AW'(INFO_WORDS);
  always_comb begin
    if ({1'b0, arr_addr} < (AW+1)'(INFO_WORDS)) begin
      seg_base = {arr_addr[AW-1:ISEG_AW], {ISEG_AW{1'b0}}};
      seg_len  = (AW+1)'(INFO_SEG_WORDS);
    end else begin
      seg_base = AW'(INFO_WORDS) + {off_main[AW-1:MSEG_AW], {MSEG_AW{1'b0}}};
      seg_len  = (AW+1)'(MAIN_SEG_WORDS);
    end
  end

  always_comb begin
    case (mode)
      OP_SEG_ERASE:  limit = TW'(SEG_ERASE_TICKS);
      OP_MASS_ERASE: limit = TW'(MASS_ERASE_TICKS);
      default:       limit = TW'(PROG_TICKS);
    endcase
  end

  assign erase_done = done && (op_q != OP_PROG);

  flash_seq_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .arr_bad    (arr_bad),
    .erase_done (erase_done),
    .mode       (mode),
    .src_sel    (src_sel),
    .div_n      (div_n),
    .locked     (locked),
    .viol       (acc_viol)
  );

  flash_seq_timer #(.TW(TW), .DIVW(6)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .limit    (limit),
    .src_tick (src_tick),
    .src_sel  (src_sel),
    .div_n    (div_n),
    .busy     (busy),
    .done     (done)
  );

  // Operation sequencing: one program step or an erase walk
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OP_READ;
      prog_addr <= '0;
      prog_data <= '0;
      prog_step <= 1'b0;
      erase_ptr <= '0;
      erase_rem <= '0;
    end else begin
      prog_step <= 1'b0;
      if (start) begin
        op_q <= mode;
        case (mode)
          OP_PROG: begin
            prog_addr <= arr_addr;
            prog_data <= arr_wdata;
            prog_step <= 1'b1;
          end
          OP_SEG_ERASE: begin
            erase_ptr <= seg_base;
            erase_rem <= seg_len;
          end
          OP_MASS_ERASE: begin
            erase_ptr <= AW'(INFO_WORDS);
            erase_rem <= (AW+1)'(MAIN_WORDS);
          end
          default: ;
        endcase
      end else if (erase_rem != '0) begin
        erase_ptr <= erase_ptr + AW'(1);
        erase_rem <= erase_rem - (AW+1)'(1);
      end
    end
  end

  assign mem_we    = prog_step || (erase_rem != '0);
  assign mem_waddr = prog_step ? prog_addr : erase_ptr;
  assign mem_wdata = prog_step ? (mem_q & prog_data) : {DW{1'b1}};

  flash_seq_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (arr_re || start),
    .raddr (arr_addr),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         blank_q <= 1'b0;
    else if (start)  blank_q <= 1'b1;
    else if (arr_re) blank_q <= busy;
  end

  assign arr_rdata = blank_q ? DW'(BUSY_FILL) : mem_q;
endmodule

// File: rtl/flash_seq_checks.sv
module flash_seq_checks #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [15:0]   cfg_wdata,
  input logic          arr_we,
  input logic          arr_re,
  input logic [DW-1:0] arr_rdata,
  input logic          busy,
  input logic          acc_viol,
  input logic          locked,
  input logic [AW:0]   erase_rem
);
  assert_bad_key_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[15:8] != 8'hA5) |=> acc_viol);

  assert_lock_needs_write_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(locked) |-> $past(cfg_we));

  assert_locked_write_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (arr_we && locked) |=> acc_viol);

  assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(arr_we && !locked));

  assert_busy_read_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (arr_re && busy) |=> (arr_rdata == DW'(16'h3FFF)));

  assert_busy_write_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (arr_we && busy) |=> acc_viol);

  assert_walk_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (erase_rem == '0));
endmodule

bind flash_seq flash_seq_checks #(.AW(AW), .DW(DW)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .arr_we    (arr_we),
  .arr_re    (arr_re),
  .arr_rdata (arr_rdata),
  .busy      (busy),
  .acc_viol  (acc_viol),
  .locked    (locked),
  .erase_rem (erase_rem)
);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        arr_we = 1'b0;
  logic        arr_re = 1'b0;
  logic [10:0] arr_addr = '0;
  logic [15:0] arr_wdata = '0;
  logic [15:0] arr_rdata;
  logic [2:0]  src_tick = 3'b101;
  logic        busy;
  logic        acc_viol;
  logic        locked;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          pend = 0;

  always #10 clk = ~clk;

  flash_seq u_flash_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .arr_we(arr_we), .arr_re(arr_re), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata), .src_tick(src_tick), .busy(busy), .acc_viol(acc_viol),
    .locked(locked)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    cyc();
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic awrite(input logic [10:0] a, input logic [15:0] d);
    cyc();
    arr_we = 1'b1; arr_addr = a; arr_wdata = d;
    cyc();
    arr_we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, input logic [15:0] e, input string tag);
    cyc();
    arr_re = 1'b1; arr_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    cyc();
    arr_re = 1'b0;
    cyc();
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin
      n++;
      cyc();
    end
  endtask

  // Scoreboard monitor: read data is due one edge after arr_re
  always @(negedge clk) begin
    if (pend) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (arr_rdata !== e) begin
        errors++;
        $display("FAIL %s read actual=%0h expected=%0h", t, arr_rdata, e);
      end
    end
    pend = arr_re;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk(locked == 1'b1, "R1 locked", locked, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(acc_viol == 1'b0, "R1 viol", acc_viol, 0);

    // R3 write while locked
    awrite(11'd5, 16'h0000);
    chk(acc_viol == 1'b1, "R3 locked write", acc_viol, 1);
    chk(busy == 1'b0, "R3 no start", busy, 0);
    // R11 clear, keep lock
    cfg(2'd2, 16'hA503);
    chk(acc_viol == 1'b0, "R11 clear", acc_viol, 0);
    chk(locked == 1'b1, "R11 still locked", locked, 1);

    // R2 bad key ignored
    cfg(2'd2, 16'h5A00);
    chk(acc_viol == 1'b1, "R2 bad key flag", acc_viol, 1);
    chk(locked == 1'b1, "R2 bad key ignored", locked, 1);
    cfg(2'd2, 16'hA502);
    chk(locked == 1'b0, "R2 unlock", locked, 0);

    // R3 read mode write rejected
    awrite(11'd5, 16'h0000);
    chk(acc_viol == 1'b1 && busy == 1'b0, "R3 read mode", acc_viol, 1);
    cfg(2'd2, 16'hA502);

    // R5 and R7: segment erase of both info segments
    cfg(2'd1, 16'hA500);
    cfg(2'd0, 16'hA501);
    awrite(11'd3, 16'h1234);
    busy_len(n);
    chk(n == 4819, "R7 seg erase ticks", n, 4819);
    // R10 erase bit cleared: next write rejected
    awrite(11'd70, 16'h0);
    chk(acc_viol == 1'b1 && busy == 1'b0, "R10 erase bit cleared", acc_viol, 1);
    cfg(2'd2, 16'hA502);
    cfg(2'd0, 16'hA501);
    awrite(11'd70, 16'h0);
    busy_len(n);

    // R6 mass erase
    cfg(2'd0, 16'hA502);
    awrite(11'd200, 16'h0);
    busy_len(n);
    chk(n == 5297, "R7 mass erase ticks", n, 5297);

    // R4 program semantics
    cfg(2'd0, 16'hA504);
    awrite(11'd0, 16'h0F0F);
    busy_len(n);
    chk(n == 35, "R7 program ticks", n, 35);
    rd(11'd0, 16'h0F0F, "R4 first program");
    awrite(11'd0, 16'h3C3C);
    busy_len(n);
    rd(11'd0, 16'h0C0C, "R4 AND program");
    chk(acc_viol == 1'b0, "R10 program bit kept", acc_viol, 0);
    awrite(11'd63, 16'h1234);  busy_len(n);
    awrite(11'd64, 16'h5678);  busy_len(n);
    awrite(11'd127, 16'hAAAA); busy_len(n);
    awrite(11'd128, 16'h5555); busy_len(n);
    awrite(11'd383, 16'h1111); busy_len(n);
    awrite(11'd384, 16'h2222); busy_len(n);

    // R7 divider with block program mode
    cfg(2'd0, 16'hA508);
    cfg(2'd1, 16'hA502);
    awrite(11'd385, 16'h00FF);
    busy_len(n);
    chk(n == 105, "R7 divide by three", n, 105);
    rd(11'd385, 16'h00FF, "R4 block program");
    cfg(2'd1, 16'hA500);

    // R8 and R9 while busy
    awrite(11'd386, 16'hF0F0);
    rd(11'd386, 16'h3FFF, "R8 read while busy");
    awrite(11'd387, 16'h0000);
    chk(acc_viol == 1'b1, "R9 busy write flag", acc_viol, 1);
    busy_len(n);
    rd(11'd386, 16'hF0F0, "R9 running op intact");
    rd(11'd387, 16'hFFFF, "R9 busy write ignored");
    cfg(2'd2, 16'hA502);

    // R3 out of range
    awrite(11'd1200, 16'h0);
    chk(acc_viol == 1'b1 && busy == 1'b0, "R3 out of range", acc_viol, 1);
    cfg(2'd2, 16'hA502);

    // R5 segment boundaries
    cfg(2'd0, 16'hA501);
    awrite(11'd74, 16'h0);
    busy_len(n);
    rd(11'd63, 16'h1234, "R5 info seg0 kept");
    rd(11'd64, 16'hFFFF, "R5 info seg1 low");
    rd(11'd127, 16'hFFFF, "R5 info seg1 high");
    rd(11'd128, 16'h5555, "R5 main seg0 kept");
    cfg(2'd0, 16'hA501);
    awrite(11'd200, 16'h0);
    busy_len(n);
    rd(11'd128, 16'hFFFF, "R5 main seg0 low");
    rd(11'd383, 16'hFFFF, "R5 main seg0 high");
    rd(11'd384, 16'h2222, "R5 main seg1 kept");

    // R6 priority and info preservation
    cfg(2'd0, 16'hA503);
    awrite(11'd5, 16'h0);
    busy_len(n);
    chk(n == 5297, "R6 mass wins", n, 5297);
    rd(11'd0, 16'h0C0C, "R6 info kept");
    rd(11'd63, 16'h1234, "R6 info kept high");
    rd(11'd384, 16'hFFFF, "R6 main erased");
    rd(11'd1151, 16'hFFFF, "R6 last word erased");

    // R7 source select: source 1 is held low
    cfg(2'd0, 16'hA504);
    cfg(2'd1, 16'hA540);
    awrite(11'd390, 16'h0000);
    repeat (100) cyc();
    chk(busy == 1'b1, "R7 idle source stalls", busy, 1);
    cfg(2'd1, 16'hA5C0);
    busy_len(n);
    chk(n < 40, "R7 source three maps to two", n, 35);
    rd(11'd390, 16'h0000, "R7 program done");

    // R3 relock
    cfg(2'd2, 16'hA501);
    awrite(11'd391, 16'h0000);
    chk(acc_viol == 1'b1 && busy == 1'b0, "R3 relocked", acc_viol, 1);
    rd(11'd391, 16'hFFFF, "R3 locked write ignored");

    repeat (3) cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule